// File: doc/BRIEF.md
# I2C Register Slave with Output Hold

This block is an I2C slave that exposes a small byte-addressed register space to a bus master. The space holds an eight-byte RAM table, an 8-bit virtual input register, a few read-only protected configuration bytes, and unmapped addresses. The virtual input register drives eight outputs. All storage loads parameter-set initial values at reset. The slave answers only when a 4-bit device code inside the control byte equals its own parameter, so up to sixteen such slaves can share one bus.

SCL and SDA are sampled against the system clock. The slave pulls SDA low only through an open-drain enable. A bus enable input connects the slave to the pins or cuts it off from them. A write updates storage only when the acknowledge clock of each data byte ends.

A hold output lets the surrounding logic freeze its general-purpose outputs while a transfer is under way. For a read, the hold covers the transfer up to the end of the address phase. For a write, it covers the transfer up to STOP.

Top module: `i2c_hold_slave`

## Requirements
- R1: The slave acknowledges a control byte only when bits [6:3] equal DEV_CODE. Bit 0 selects the direction (1 = read) and bits 7, 2 and 1 are ignored. On a mismatch, SDA stays released during the acknowledge clock, the rest of the transfer is ignored, and ioHold drops at the end of that byte.
- R2: While busEn is low, sdaOe and ioHold are low, no byte is acknowledged, and no storage changes.
- R3: Written data changes storage only when SCL falls at the end of the acknowledge clock that follows the data byte. It does not change storage during the data bits or while that acknowledge clock is high.
- R4: When latchEn is high at START and the transfer is a read, ioHold is high from START through the acknowledge clock of the control byte, and low afterwards.
- R5: When latchEn is high at START and the transfer is a write, ioHold is high from START until STOP.
- R6: When latchEn is low at START, ioHold stays low for the whole transfer, and writes still take effect.
- R7: Addresses RAM_BASE to RAM_BASE+7 form a read/write RAM table. After reset, byte i holds RAM_INIT[8i+7:8i].
- R8: Address VIN_ADDR is a read/write register that drives vinOut. After reset it holds VIN_INIT.
- R9: Addresses PROT_BASE to PROT_BASE+NUM_PROT-1 read back PROT_INIT[8k+7:8k]. Writes to them are acknowledged and leave them unchanged. Any other unmapped address reads 0x00 and ignores writes, which are still acknowledged.
- R10: In a write, the first byte after the control byte loads the address pointer. Each later data byte is stored at the pointer, and the pointer then increments.
- R11: A read returns the byte at the pointer, MSB first, and the pointer increments after every byte.
- R12: After the master answers a read byte with NACK, the slave keeps SDA released until STOP or START.
- R13: SDA is sampled on SCL rising edges. A START or repeated START, including one that arrives in the middle of a byte, restarts byte reception with a new control byte. sdaOe changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset, loads all initial values |
| busEn | input | 1 | Connects the slave to the bus pins when high |
| latchEn | input | 1 | Enables the output hold window |
| sclIn | input | 1 | SCL pin level |
| sdaIn | input | 1 | SDA pin level |
| sdaOe | output | 1 | High pulls SDA low (open-drain enable) |
| ioHold | output | 1 | Freeze request for general-purpose outputs |
| vinOut | output | 8 | Virtual input register outputs |

## Verification
The bench builds the slave with DEV_CODE = 4'b1010. This alternating pattern makes the test fail if the code bits are shifted or reversed, and the mismatching code 4'b0101 flips every bit of it. RAM_INIT, VIN_INIT and PROT_INIT are given distinct non-zero bytes, so reset loading, protected read-back and auto-increment order can all be told apart on the bus. Address parameters keep their defaults. The half SCL period of twelve clocks leaves room to observe the acknowledge clock while it is high, before the commit edge.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_CNT_W = 4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CTRL,
    PH_WADR,
    PH_WDAT,
    PH_RDAT,
    PH_WAIT
  } phase_t;

  // strobes from control to datapath, one clock wide
  typedef struct packed {
    logic shiftEn;   // shift sampled SDA into the receive byte
    logic ptrLoad;   // receive byte becomes the address pointer
    logic ptrInc;    // advance pointer
    logic wrCommit;  // store receive byte at pointer
    logic txLoad;    // capture the peeked byte for transmission
    logic txNext;    // peek at pointer+1 instead of pointer
  } dpStrobe_t;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic busEn,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  logic [STAGES-1:0] sclSh;
  logic [STAGES-1:0] sdaSh;
  logic sclPrev;
  logic sdaPrev;
  logic sclLvl;

  // a disconnected bus looks idle (both lines high)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSh   <= '1;
      sdaSh   <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSh   <= {sclSh[STAGES-2:0], busEn ? sclIn : 1'b1};
      sdaSh   <= {sdaSh[STAGES-2:0], busEn ? sdaIn : 1'b1};
      sclPrev <= sclSh[STAGES-1];
      sdaPrev <= sdaSh[STAGES-1];
    end
  end

  assign sclLvl   = sclSh[STAGES-1];
  assign sdaLvl   = sdaSh[STAGES-1];
  assign sclRise  = sclLvl & ~sclPrev;
  assign sclFall  = ~sclLvl & sclPrev;
  assign startDet = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopDet  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;
endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
  import i2cs_pkg::*;
#(
  parameter logic [3:0] DEV_CODE = 4'h0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busEn,
  input  logic              latchEn,
  input  logic              sdaLvl,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic [3:0]        ctrlCode,
  input  logic              rwBit,
  input  logic [BYTE_W-1:0] txByte,
  input  logic [BYTE_W-1:0] peekByte,
  output dpStrobe_t         strobe,
  output logic              sdaOe,
  output logic              ioHold
);
  phase_t               phase;
  logic [BIT_CNT_W-1:0] bitCnt;
  logic                 masterAck;
  logic                 active;
  logic                 codeHit;
  logic                 ackEnd;

  assign active  = (phase != PH_IDLE) && (phase != PH_WAIT);
  assign codeHit = (ctrlCode == DEV_CODE);
  assign ackEnd  = active && sclFall && (bitCnt == BIT_CNT_W'(9));

  always_comb begin
    strobe          = '0;
    strobe.shiftEn  = active && sclRise && (bitCnt < BIT_CNT_W'(8));
    strobe.ptrLoad  = ackEnd && (phase == PH_WADR);
    strobe.wrCommit = ackEnd && (phase == PH_WDAT);
    strobe.ptrInc   = ackEnd && ((phase == PH_WDAT) || (phase == PH_RDAT));
    strobe.txNext   = (phase == PH_RDAT);
    strobe.txLoad   = ackEnd && (((phase == PH_CTRL) && rwBit) ||
                                 ((phase == PH_RDAT) && masterAck));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      bitCnt    <= '0;
      masterAck <= 1'b0;
      sdaOe     <= 1'b0;
      ioHold    <= 1'b0;
    end else if (!busEn) begin
      phase     <= PH_IDLE;
      bitCnt    <= '0;
      masterAck <= 1'b0;
      sdaOe     <= 1'b0;
      ioHold    <= 1'b0;
    end else if (startDet) begin
      phase  <= PH_CTRL;
      bitCnt <= '0;
      sdaOe  <= 1'b0;
      ioHold <= latchEn;
    end else if (stopDet) begin
      phase  <= PH_IDLE;
      bitCnt <= '0;
      sdaOe  <= 1'b0;
      ioHold <= 1'b0;
    end else if (active && sclRise) begin
      if (bitCnt < BIT_CNT_W'(8)) begin
        bitCnt <= bitCnt + BIT_CNT_W'(1);
      end else if (bitCnt == BIT_CNT_W'(8)) begin
        bitCnt <= BIT_CNT_W'(9);
        if (phase == PH_RDAT) masterAck <= ~sdaLvl;
      end
    end else if (active && sclFall) begin
      if (bitCnt == BIT_CNT_W'(8)) begin
        // low phase ahead of the acknowledge clock
        unique case (phase)
          PH_CTRL: begin
            if (codeHit) begin
              sdaOe <= 1'b1;
            end else begin
              phase  <= PH_WAIT;
              sdaOe  <= 1'b0;
              ioHold <= 1'b0;
            end
          end
          PH_WADR, PH_WDAT: sdaOe <= 1'b1;
          default:          sdaOe <= 1'b0;
        endcase
      end else if (bitCnt == BIT_CNT_W'(9)) begin
        // acknowledge clock has ended
        bitCnt <= '0;
        unique case (phase)
          PH_CTRL: begin
            if (rwBit) begin
              phase  <= PH_RDAT;
              ioHold <= 1'b0;
              sdaOe  <= ~peekByte[BYTE_W-1];
            end else begin
              phase <= PH_WADR;
              sdaOe <= 1'b0;
            end
          end
          PH_WADR: begin
            phase <= PH_WDAT;
            sdaOe <= 1'b0;
          end
          PH_RDAT: begin
            if (masterAck) begin
              sdaOe <= ~peekByte[BYTE_W-1];
            end else begin
              phase <= PH_WAIT;
              sdaOe <= 1'b0;
            end
          end
          default: sdaOe <= 1'b0;
        endcase
      end else if (phase == PH_RDAT && bitCnt != '0) begin
        sdaOe <= ~txByte[3'd7 - bitCnt[2:0]];
      end
    end
  end
endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs
  import i2cs_pkg::*;
#(
  parameter int                   ADDR_W    = 8,
  parameter int                   RAM_DEPTH = 8,
  parameter logic [ADDR_W-1:0]    RAM_BASE  = 8'hD8,
  parameter logic [RAM_DEPTH*8-1:0] RAM_INIT = '0,
  parameter logic [ADDR_W-1:0]    VIN_ADDR  = 8'hF0,
  parameter logic [7:0]           VIN_INIT  = 8'h00,
  parameter int                   NUM_PROT  = 3,
  parameter logic [ADDR_W-1:0]    PROT_BASE = 8'hF8,
  parameter logic [NUM_PROT*8-1:0] PROT_INIT = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              sdaLvl,
  output logic [BYTE_W-1:0] rxByte,
  output logic [BYTE_W-1:0] txByte,
  output logic [BYTE_W-1:0] peekByte,
  output logic [BYTE_W-1:0] vinOut
);
  logic [BYTE_W-1:0] ramQ [RAM_DEPTH];
  logic [BYTE_W-1:0] vinQ;
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] peekAddr;
  logic [BYTE_W-1:0] protQ [NUM_PROT];

  // protected bytes are fixed by parameter
  for (genvar k = 0; k < NUM_PROT; k++) begin : g_prot
    assign protQ[k] = PROT_INIT[8*k +: 8];
  end

  function automatic logic [BYTE_W-1:0] readAt(input logic [ADDR_W-1:0] a);
    logic [BYTE_W-1:0] r;
    r = '0;
    for (int i = 0; i < RAM_DEPTH; i++) begin
      if (a == ADDR_W'(int'(RAM_BASE) + i)) r = ramQ[i];
    end
    for (int k = 0; k < NUM_PROT; k++) begin
      if (a == ADDR_W'(int'(PROT_BASE) + k)) r = protQ[k];
    end
    if (a == VIN_ADDR) r = vinQ;
    return r;
  endfunction

  assign peekAddr = strobe.txNext ? ptr + ADDR_W'(1) : ptr;
  assign peekByte = readAt(peekAddr);
  assign vinOut   = vinQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      txByte <= '0;
      ptr    <= '0;
    end else begin
      if (strobe.shiftEn) rxByte <= {rxByte[BYTE_W-2:0], sdaLvl};
      if (strobe.txLoad)  txByte <= peekByte;
      if (strobe.ptrLoad) ptr <= ADDR_W'(rxByte);
      else if (strobe.ptrInc) ptr <= ptr + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < RAM_DEPTH; i++) ramQ[i] <= RAM_INIT[8*i +: 8];
      vinQ <= VIN_INIT;
    end else if (strobe.wrCommit) begin
      for (int i = 0; i < RAM_DEPTH; i++) begin
        if (ptr == ADDR_W'(int'(RAM_BASE) + i)) ramQ[i] <= rxByte;
      end
      if (ptr == VIN_ADDR) vinQ <= rxByte;
    end
  end
endmodule

// File: rtl/i2c_hold_slave.sv
module i2c_hold_slave
  import i2cs_pkg::*;
#(
  parameter logic [3:0]             DEV_CODE    = 4'h0,
  parameter int                     ADDR_W      = 8,
  parameter int                     RAM_DEPTH   = 8,
  parameter logic [ADDR_W-1:0]      RAM_BASE    = 8'hD8,
  parameter logic [RAM_DEPTH*8-1:0] RAM_INIT    = '0,
  parameter logic [ADDR_W-1:0]      VIN_ADDR    = 8'hF0,
  parameter logic [7:0]             VIN_INIT    = 8'h00,
  parameter int                     NUM_PROT    = 3,
  parameter logic [ADDR_W-1:0]      PROT_BASE   = 8'hF8,
  parameter logic [NUM_PROT*8-1:0]  PROT_INIT   = '0,
  parameter int                     SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busEn,
  input  logic       latchEn,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOe,
  output logic       ioHold,
  output logic [7:0] vinOut
);
  logic              sdaLvl;
  logic              sclRise;
  logic              sclFall;
  logic              startDet;
  logic              stopDet;
  dpStrobe_t         strobe;
  logic [BYTE_W-1:0] rxByte;
  logic [BYTE_W-1:0] txByte;
  logic [BYTE_W-1:0] peekByte;

  i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .busEn(busEn), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  i2cs_ctrl #(.DEV_CODE(DEV_CODE)) u_ctrl (
    .clk(clk), .rstN(rstN), .busEn(busEn), .latchEn(latchEn),
    .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet),
    .ctrlCode(rxByte[6:3]), .rwBit(rxByte[0]),
    .txByte(txByte), .peekByte(peekByte),
    .strobe(strobe), .sdaOe(sdaOe), .ioHold(ioHold)
  );

  i2cs_regs #(
    .ADDR_W(ADDR_W), .RAM_DEPTH(RAM_DEPTH), .RAM_BASE(RAM_BASE),
    .RAM_INIT(RAM_INIT), .VIN_ADDR(VIN_ADDR), .VIN_INIT(VIN_INIT),
    .NUM_PROT(NUM_PROT), .PROT_BASE(PROT_BASE), .PROT_INIT(PROT_INIT)
  ) u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaLvl(sdaLvl),
    .rxByte(rxByte), .txByte(txByte), .peekByte(peekByte), .vinOut(vinOut)
  );
endmodule

// File: rtl/i2c_hold_slave_chk.sv
module i2c_hold_slave_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busEn,
  input logic       sclIn,
  input logic       sdaOe,
  input logic       ioHold,
  input logic [7:0] vinOut,
  input logic       startDet
);
  a_r2_oe_released: assert property (@(posedge clk) disable iff (!rstN)
    !busEn |=> !sdaOe);

  a_r2_hold_released: assert property (@(posedge clk) disable iff (!rstN)
    !busEn |=> !ioHold);

  a_r3_commit_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(vinOut) |-> !sclIn);

  a_r4_hold_rises_on_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ioHold) |-> $past(startDet));

  a_r13_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    (busEn && $past(busEn) && !$stable(sdaOe)) |-> !sclIn);
endmodule

bind i2c_hold_slave i2c_hold_slave_chk u_chk (
  .clk(clk), .rstN(rstN), .busEn(busEn), .sclIn(sclIn), .sdaOe(sdaOe),
  .ioHold(ioHold), .vinOut(vinOut), .startDet(startDet)
);

// File: tb/i2c_hold_slave_tb.sv
module i2c_hold_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int H = 12;
  localparam logic [3:0] DEV = 4'b1010;
  localparam logic [3:0] BAD = 4'b0101;
  localparam logic [63:0] RAM_INIT = 64'h8877_6655_4433_2211;
  localparam logic [7:0]  VIN_INIT = 8'h3C;
  localparam logic [23:0] PROT_INIT = 24'hC2_B1_A0;

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] wr;
    logic [7:0] exp;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{8'hD8, 8'h5A, 8'h5A},
    '{8'hDF, 8'hC3, 8'hC3},
    '{8'hF0, 8'h96, 8'h96},
    '{8'hF8, 8'hFF, 8'hA0},
    '{8'hFA, 8'h00, 8'hC2},
    '{8'h10, 8'h77, 8'h00}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busEn = 1'b1;
  logic latchEn = 1'b1;
  logic scl = 1'b1;
  logic mSda = 1'b1;
  logic sdaOe;
  logic ioHold;
  logic [7:0] vinOut;
  wire sdaBus = mSda & ~sdaOe;

  int checks = 0;
  int failures = 0;
  logic done = 1'b0;
  logic lastAck;
  logic holdAtAck;
  logic [7:0] vinAtAck;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_hold_slave #(
    .DEV_CODE(DEV), .RAM_INIT(RAM_INIT), .VIN_INIT(VIN_INIT),
    .PROT_INIT(PROT_INIT)
  ) u_dut (
    .clk(clk), .rstN(rstN), .busEn(busEn), .latchEn(latchEn),
    .sclIn(scl), .sdaIn(sdaBus), .sdaOe(sdaOe), .ioHold(ioHold),
    .vinOut(vinOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    tick(2); mSda = 1'b1; tick(H);
    scl = 1'b1; tick(H);
    mSda = 1'b0; tick(H);
    scl = 1'b0;
  endtask

  task automatic busStop();
    tick(2); mSda = 1'b0; tick(H);
    scl = 1'b1; tick(H);
    mSda = 1'b1; tick(H);
  endtask

  task automatic sendBit(input logic b);
    tick(2); mSda = b; tick(H-2);
    scl = 1'b1; tick(H);
    scl = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    tick(2); mSda = 1'b1; tick(H-2);
    scl = 1'b1; tick(H/2);
    lastAck = sdaBus; holdAtAck = ioHold; vinAtAck = vinOut;
    tick(H/2);
    scl = 1'b0;
  endtask

  task automatic recvByte(input logic nack, output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      tick(2); mSda = 1'b1; tick(H-2);
      scl = 1'b1; tick(H/2);
      b = {b[6:0], sdaBus};
      tick(H/2);
      scl = 1'b0;
    end
    sendBit(nack);
  endtask

  function automatic logic [7:0] ctl(input logic [3:0] code, input logic rd);
    return {1'b0, code, 2'b00, rd};
  endfunction

  task automatic writeBytes(input logic [7:0] addr, input logic [31:0] data,
                            input int n, output logic allAck);
    allAck = 1'b1;
    busStart();
    sendByte(ctl(DEV, 1'b0)); allAck &= ~lastAck;
    sendByte(addr);           allAck &= ~lastAck;
    for (int k = 0; k < n; k++) begin
      sendByte(data[8*k +: 8]); allAck &= ~lastAck;
    end
    busStop();
  endtask

  task automatic readBytes(input logic [7:0] addr, input int n,
                           output logic [31:0] got);
    logic [7:0] b;
    got = '0;
    busStart();
    sendByte(ctl(DEV, 1'b0));
    sendByte(addr);
    busStart();
    sendByte(ctl(DEV, 1'b1));
    for (int k = 0; k < n; k++) begin
      recvByte(k == n-1, b);
      got[8*k +: 8] = b;
    end
    busStop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic ok;
    logic [31:0] got;
    logic [7:0] b;
    tick(5);
    rstN = 1'b1;
    tick(3);

    // reset state
    chk("R2 reset sdaOe", sdaOe, 0);
    chk("R5 reset ioHold", ioHold, 0);
    chk("R8 reset vinOut", vinOut, VIN_INIT);
    readBytes(8'hD9, 2, got);
    chk("R7 R11 reset ram D9/DA", got[15:0], 16'h3322);

    // vector table
    for (int v = 0; v < 6; v++) begin
      writeBytes(VEC[v].addr, {24'h0, VEC[v].wr}, 1, ok);
      chk("R9 R10 write acked", ok, 1);
      readBytes(VEC[v].addr, 1, got);
      if (VEC[v].addr >= 8'hD8 && VEC[v].addr <= 8'hDF)
        chk("R7 ram vector", got[7:0], VEC[v].exp);
      else if (VEC[v].addr == 8'hF0)
        chk("R8 vin vector", got[7:0], VEC[v].exp);
      else
        chk("R9 protected/unmapped vector", got[7:0], VEC[v].exp);
    end
    chk("R8 vinOut follows register", vinOut, 8'h96);

    // auto-increment burst
    writeBytes(8'hDB, 32'h0403_0201, 4, ok);
    chk("R10 burst acked", ok, 1);
    readBytes(8'hDB, 4, got);
    chk("R10 R11 burst readback", got, 32'h0403_0201);

    // commit timing and write hold window
    latchEn = 1'b1;
    busStart();
    tick(3);
    chk("R5 hold after START", ioHold, 1);
    sendByte(ctl(DEV, 1'b0));
    sendByte(8'hF0);
    sendByte(8'h5C);
    chk("R3 vin unchanged during ack clock", vinAtAck, 8'h96);
    chk("R5 hold through data ack", holdAtAck, 1);
    tick(H/2);
    chk("R3 vin committed after ack", vinOut, 8'h5C);
    chk("R5 hold before STOP", ioHold, 1);
    busStop();
    tick(3);
    chk("R5 hold released at STOP", ioHold, 0);

    // read hold window
    busStart();
    tick(3);
    chk("R4 hold after START", ioHold, 1);
    sendByte(ctl(DEV, 1'b1));
    chk("R4 hold during control ack", holdAtAck, 1);
    tick(H/2);
    chk("R4 hold released after address", ioHold, 0);
    recvByte(1'b1, b);
    chk("R4 hold low during data", ioHold, 0);
    busStop();

    // latching disabled
    latchEn = 1'b0;
    busStart();
    tick(3);
    chk("R6 no hold at START", ioHold, 0);
    sendByte(ctl(DEV, 1'b0));
    sendByte(8'hD8);
    sendByte(8'h66);
    chk("R6 no hold in write", holdAtAck, 0);
    busStop();
    readBytes(8'hD8, 1, got);
    chk("R6 write still applied", got[7:0], 8'h66);
    latchEn = 1'b1;

    // device code mismatch
    busStart();
    sendByte(ctl(BAD, 1'b0));
    chk("R1 mismatch not acked", lastAck, 1);
    chk("R1 hold dropped on mismatch", holdAtAck, 0);
    sendByte(8'hF0);
    chk("R1 mismatch addr not acked", lastAck, 1);
    sendByte(8'h11);
    busStop();
    chk("R1 vin untouched by mismatch", vinOut, 8'h5C);
    busStart();
    sendByte({1'b1, DEV, 2'b11, 1'b0});
    chk("R1 don't-care bits ignored", lastAck, 0);
    busStop();

    // bus disabled
    busEn = 1'b0;
    tick(3);
    chk("R2 oe low when disabled", sdaOe, 0);
    writeBytes(8'hD8, 32'h99, 1, ok);
    chk("R2 no ack when disabled", lastAck, 1);
    chk("R2 no hold when disabled", holdAtAck, 0);
    busEn = 1'b1;
    tick(3);
    readBytes(8'hD8, 1, got);
    chk("R2 ram untouched when disabled", got[7:0], 8'h66);

    // NACK release
    busStart();
    sendByte(ctl(DEV, 1'b0));
    sendByte(8'hD8);
    busStart();
    sendByte(ctl(DEV, 1'b1));
    recvByte(1'b1, b);
    chk("R11 first read byte", b, 8'h66);
    recvByte(1'b1, b);
    chk("R12 SDA released after NACK", b, 8'hFF);
    busStop();

    // START in the middle of a byte
    busStart();
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);
    readBytes(8'hF0, 1, got);
    chk("R13 mid-byte START restarts", got[7:0], 8'h5C);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule